// File: doc/BRIEF.md
# Pipelined Limb-Product Wide Multiplier

This block forms the full 512-bit product of two 256-bit unsigned operands. Each operand is cut into four 64-bit limbs. Two 64×64 multipliers work side by side in a first pipeline stage, and each forms one limb product per cycle. The sixteen limb products are issued as eight pairs in a fixed diagonal order. A second stage, one cycle behind, shifts each registered partial product to its weight and adds both into a 512-bit accumulator. A small controller steps through the schedule. It drives the limb-select multiplexers, the shift selection and the accumulator write.

A caller presents both operands with a start strobe. The result appears on the product port with a one-cycle valid pulse. Consecutive multiplications overlap: a new pair of operands can be taken in the last issue cycle of the current operation, so that operation's final accumulation runs in parallel with the new operation's first limb pair. The throughput is then one product every eight cycles. No modular reduction is done here.

Top module: `wide_mul_pipe`

## Requirements
- R1: When `out_valid` is high, `product` equals the full unsigned 512-bit product of the `a_in` and `b_in` values sampled at the accepting edge, including all-ones operands where carries run through every limb.
- R2: `out_valid` is high for exactly one cycle per accepted operation. It rises after the 9th rising edge following the accepting edge.
- R3: With starts offered on every cycle, operations are accepted every 8 cycles. The valid pulses are spaced 8 cycles apart.
- R4: A start is accepted when the block is idle, or in the eighth (final) issue cycle of the running operation, that is on the 8th edge after the previous accept. A start offered at any other time is ignored and yields no result.
- R5: `product` keeps its value in every cycle in which `out_valid` is low.
- R6: Each operation's result is independent of earlier operations. The accumulator starts from zero for every operation, including overlapped ones.
- R7: While `rst` (synchronous, active high) is asserted, `out_valid` reads 0 and `product` reads 0 after the next edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous reset, active high |
| in_valid | input | 1 | Start strobe for the operands |
| a_in | input | 256 | Multiplicand |
| b_in | input | 256 | Multiplier |
| out_valid | output | 1 | One-cycle pulse marking a new product |
| product | output | 512 | Full product, held between results |

## Verification
The hardest case to reach from the ports is a start that lands in the final issue cycle of an operation. In that cycle the new operands are captured while the old operation still has its last pair to accumulate, and the new operation must clear the accumulator without losing the old result. The bench reaches this case by holding the start strobe high for many cycles with fresh operands on each cycle. It also sends starts at chosen offsets inside a running operation, so the cycles before the accept window get rejected starts and the window cycle itself gets an accepted one. A behavioural model that checks every cycle confirms which starts were taken and what each result is.

// File: rtl/wmp_pkg.sv
package wmp_pkg;

    // Limb products are ordered by diagonal (row + col), and inside a
    // diagonal by descending row index. These helpers return the row
    // (multiplicand limb) and column (multiplier limb) of product n.
    function automatic int sched_row(input int limbs, input int n);
        int cnt;
        int res;
        cnt = 0;
        res = 0;
        for (int d = 0; d < 2 * limbs - 1; d++) begin
            for (int i = limbs - 1; i >= 0; i--) begin
                if ((d - i >= 0) && (d - i < limbs)) begin
                    if (cnt == n) res = i;
                    cnt++;
                end
            end
        end
        return res;
    endfunction

    function automatic int sched_col(input int limbs, input int n);
        int cnt;
        int res;
        cnt = 0;
        res = 0;
        for (int d = 0; d < 2 * limbs - 1; d++) begin
            for (int i = limbs - 1; i >= 0; i--) begin
                if ((d - i >= 0) && (d - i < limbs)) begin
                    if (cnt == n) res = d - i;
                    cnt++;
                end
            end
        end
        return res;
    endfunction

endpackage

// File: rtl/wmp_lane.sv
module wmp_lane #(
    parameter int LIMB_W = 64,
    parameter int LIMBS  = 4,
    parameter int LANE   = 0
) (
    input  logic [LIMB_W*LIMBS-1:0]             a_op,
    input  logic [LIMB_W*LIMBS-1:0]             b_op,
    input  logic [$clog2(LIMBS*LIMBS/2)-1:0]    pair,
    output logic [2*LIMB_W-1:0]                 prod,
    output logic [$clog2(2*LIMBS-1)-1:0]        diag
);
    localparam int PAIRS = LIMBS * LIMBS / 2;
    localparam int IW    = $clog2(LIMBS);
    localparam int DW    = $clog2(2 * LIMBS - 1);

    logic [IW-1:0] row_tab  [PAIRS];
    logic [IW-1:0] col_tab  [PAIRS];
    logic [DW-1:0] diag_tab [PAIRS];

    for (genvar p = 0; p < PAIRS; p++) begin : g_tab
        assign row_tab[p]  = IW'(wmp_pkg::sched_row(LIMBS, 2 * p + LANE));
        assign col_tab[p]  = IW'(wmp_pkg::sched_col(LIMBS, 2 * p + LANE));
        assign diag_tab[p] = DW'(wmp_pkg::sched_row(LIMBS, 2 * p + LANE)
                               + wmp_pkg::sched_col(LIMBS, 2 * p + LANE));
    end

    logic [IW-1:0]     row_sel;
    logic [IW-1:0]     col_sel;
    logic [LIMB_W-1:0] a_limb;
    logic [LIMB_W-1:0] b_limb;

    always_comb begin
        row_sel = row_tab[pair];
        col_sel = col_tab[pair];
        a_limb  = a_op[row_sel*LIMB_W +: LIMB_W];
        b_limb  = b_op[col_sel*LIMB_W +: LIMB_W];
        prod    = {{LIMB_W{1'b0}}, a_limb} * {{LIMB_W{1'b0}}, b_limb};
        diag    = diag_tab[pair];
    end

endmodule

// File: rtl/wmp_accum.sv
module wmp_accum #(
    parameter int LIMB_W = 64,
    parameter int LIMBS  = 4
) (
    input  logic [2*LIMB_W*LIMBS-1:0]       acc_in,
    input  logic                            clear,
    input  logic [2*LIMB_W-1:0]             p0,
    input  logic [2*LIMB_W-1:0]             p1,
    input  logic [$clog2(2*LIMBS-1)-1:0]    d0,
    input  logic [$clog2(2*LIMBS-1)-1:0]    d1,
    output logic [2*LIMB_W*LIMBS-1:0]       sum
);
    localparam int ACCW = 2 * LIMB_W * LIMBS;

    logic [ACCW-1:0] base;
    logic [ACCW-1:0] sh0;
    logic [ACCW-1:0] sh1;

    always_comb begin
        base = clear ? '0 : acc_in;
        sh0  = ACCW'(p0) << (d0 * LIMB_W);
        sh1  = ACCW'(p1) << (d1 * LIMB_W);
        sum  = base + sh0 + sh1;
    end

endmodule

// File: rtl/wide_mul_pipe.sv
module wide_mul_pipe #(
    parameter int LIMB_W = 64,
    parameter int LIMBS  = 4
) (
    input  logic                        clk,
    input  logic                        rst,
    input  logic                        in_valid,
    input  logic [LIMB_W*LIMBS-1:0]     a_in,
    input  logic [LIMB_W*LIMBS-1:0]     b_in,
    output logic                        out_valid,
    output logic [2*LIMB_W*LIMBS-1:0]   product
);
    localparam int OPW   = LIMB_W * LIMBS;
    localparam int ACCW  = 2 * OPW;
    localparam int PAIRS = LIMBS * LIMBS / 2;
    localparam int PW    = $clog2(PAIRS);
    localparam int DW    = $clog2(2 * LIMBS - 1);
    localparam int PPW   = 2 * LIMB_W;
    localparam logic [PW-1:0] LAST = PW'(PAIRS - 1);

    typedef struct packed {
        logic [OPW-1:0]  a;
        logic [OPW-1:0]  b;
        logic            busy;
        logic [PW-1:0]   idx;
        logic            s2_vld;
        logic            s2_first;
        logic            s2_last;
        logic [PPW-1:0]  p0;
        logic [PPW-1:0]  p1;
        logic [DW-1:0]   d0;
        logic [DW-1:0]   d1;
        logic [ACCW-1:0] acc;
        logic [ACCW-1:0] res;
        logic            ovld;
    } st_t;

    st_t st_d, st_q;

    logic [PPW-1:0]  lane_prod [2];
    logic [DW-1:0]   lane_diag [2];
    logic [ACCW-1:0] acc_sum;
    logic            accept;

    for (genvar l = 0; l < 2; l++) begin : g_lane
        wmp_lane #(
            .LIMB_W (LIMB_W),
            .LIMBS  (LIMBS),
            .LANE   (l)
        ) u_lane (
            .a_op (st_q.a),
            .b_op (st_q.b),
            .pair (st_q.idx),
            .prod (lane_prod[l]),
            .diag (lane_diag[l])
        );
    end

    wmp_accum #(
        .LIMB_W (LIMB_W),
        .LIMBS  (LIMBS)
    ) u_accum (
        .acc_in (st_q.acc),
        .clear  (st_q.s2_first),
        .p0     (st_q.p0),
        .p1     (st_q.p1),
        .d0     (st_q.d0),
        .d1     (st_q.d1),
        .sum    (acc_sum)
    );

    always_comb begin
        st_d   = st_q;
        accept = in_valid && (!st_q.busy || st_q.idx == LAST);

        // operand capture
        if (accept) begin
            st_d.a = a_in;
            st_d.b = b_in;
        end

        // stage 1: limb products into pipeline registers
        st_d.s2_vld = st_q.busy;
        if (st_q.busy) begin
            st_d.p0       = lane_prod[0];
            st_d.p1       = lane_prod[1];
            st_d.d0       = lane_diag[0];
            st_d.d1       = lane_diag[1];
            st_d.s2_first = (st_q.idx == '0);
            st_d.s2_last  = (st_q.idx == LAST);
        end else begin
            st_d.s2_first = 1'b0;
            st_d.s2_last  = 1'b0;
        end

        // schedule controller
        if (accept) begin
            st_d.busy = 1'b1;
            st_d.idx  = '0;
        end else if (st_q.busy) begin
            if (st_q.idx == LAST) begin
                st_d.busy = 1'b0;
                st_d.idx  = '0;
            end else begin
                st_d.idx = st_q.idx + PW'(1);
            end
        end

        // stage 2: shift and accumulate
        st_d.ovld = 1'b0;
        if (st_q.s2_vld) begin
            st_d.acc = acc_sum;
            if (st_q.s2_last) begin
                st_d.res  = acc_sum;
                st_d.ovld = 1'b1;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (rst) st_q <= '0;
        else     st_q <= st_d;
    end

    assign out_valid = st_q.ovld;
    assign product   = st_q.res;

    logic          issue_busy;
    logic [PW-1:0] issue_idx;
    logic          acc_vld;
    logic          acc_last;
    assign issue_busy = st_q.busy;
    assign issue_idx  = st_q.idx;
    assign acc_vld    = st_q.s2_vld;
    assign acc_last   = st_q.s2_last;

endmodule

// File: rtl/wmp_chk.sv
module wmp_chk #(
    parameter int PW   = 3,
    parameter int ACCW = 512
) (
    input logic            clk,
    input logic            rst,
    input logic            in_valid,
    input logic            out_valid,
    input logic [ACCW-1:0] product,
    input logic            busy,
    input logic [PW-1:0]   idx,
    input logic            s2_vld,
    input logic            s2_last
);
    localparam logic [PW-1:0] LAST = '1;

    p_one_shot_r2: assert property (@(posedge clk) disable iff (rst)
        out_valid |=> !out_valid);

    p_drain_r2: assert property (@(posedge clk) disable iff (rst)
        (s2_vld && s2_last) |=> out_valid);

    p_step_r3: assert property (@(posedge clk) disable iff (rst)
        (busy && idx != LAST) |=> (busy && idx == $past(idx) + PW'(1)));

    p_take_r4: assert property (@(posedge clk) disable iff (rst)
        (in_valid && !busy) |=> (busy && idx == '0));

    p_keep_r5: assert property (@(posedge clk) disable iff (rst)
        !out_valid |-> $stable(product));

    p_clear_r7: assert property (@(posedge clk)
        rst |=> (!out_valid && product == '0));

endmodule

bind wide_mul_pipe wmp_chk #(
    .PW   (PW),
    .ACCW (ACCW)
) u_wmp_chk (
    .clk       (clk),
    .rst       (rst),
    .in_valid  (in_valid),
    .out_valid (out_valid),
    .product   (product),
    .busy      (issue_busy),
    .idx       (issue_idx),
    .s2_vld    (acc_vld),
    .s2_last   (acc_last)
);

// File: tb/wide_mul_pipe_bench.sv
module wide_mul_pipe_bench;
    logic         clk = 1'b0;
    logic         rst = 1'b1;
    logic         in_valid = 1'b0;
    logic [255:0] a_in = '0;
    logic [255:0] b_in = '0;
    logic         out_valid;
    logic [511:0] product;

    always #5 clk = ~clk;

    wide_mul_pipe u_wide_mul_pipe (
        .clk       (clk),
        .rst       (rst),
        .in_valid  (in_valid),
        .a_in      (a_in),
        .b_in      (b_in),
        .out_valid (out_valid),
        .product   (product)
    );

    int           checks = 0;
    int           bad = 0;
    longint       cyc = 0;
    longint       next_ok = 0;
    longint       due_q [$];
    logic [511:0] val_q [$];
    logic [511:0] held = '0;
    int           accepts = 0;
    int           results = 0;
    string        phase = "R7";

    // behavioural reference, updated at each rising edge
    always @(posedge clk) begin
        cyc <= cyc + 1;
        if (rst) begin
            due_q.delete();
            val_q.delete();
            held    <= '0;
            next_ok <= cyc + 1;
        end else if (in_valid && (cyc + 1 >= next_ok)) begin
            logic [511:0] ea;
            logic [511:0] eb;
            ea = {256'd0, a_in};
            eb = {256'd0, b_in};
            due_q.push_back(cyc + 1 + 9);
            val_q.push_back(ea * eb);
            next_ok <= cyc + 1 + 8;
            accepts++;
        end
    end

    // compare every cycle, away from the edge
    always @(negedge clk) begin
        if (cyc > 0) begin
            logic exp_v;
            exp_v = (due_q.size() > 0) && (due_q[0] == cyc);
            if (exp_v) begin
                held = val_q[0];
                due_q.pop_front();
                val_q.pop_front();
            end
            checks++;
            if (out_valid !== exp_v) begin
                bad++;
                $display("FAIL R2 (%s) cycle %0d: out_valid=%0b expected=%0b",
                         phase, cyc, out_valid, exp_v);
            end
            checks++;
            if (product !== held) begin
                bad++;
                $display("FAIL %s (%s) cycle %0d: product=%h expected=%h",
                         exp_v ? "R1" : (rst ? "R7" : "R5"), phase, cyc, product, held);
            end
            if (exp_v) results++;
        end
    end

    task automatic give(input logic [255:0] a, input logic [255:0] b);
        @(negedge clk);
        in_valid = 1'b1;
        a_in = a;
        b_in = b;
        @(negedge clk);
        in_valid = 1'b0;
    endtask

    task automatic idle(input int n);
        for (int k = 0; k < n; k++) @(negedge clk);
    endtask

    function automatic logic [255:0] rnd256();
        logic [255:0] r;
        for (int k = 0; k < 8; k++) r[k*32 +: 32] = $urandom;
        return r;
    endfunction

    initial begin
        idle(4);
        rst = 1'b0;
        phase = "R1";
        give(256'd3, 256'd5);
        idle(12);
        give({64'd1, 64'd0, 64'd0, 64'd0}, {64'd0, 64'd0, 64'd1, 64'd2});
        idle(12);
        phase = "R1-allones";
        give('1, '1);
        idle(12);
        // R3 and R6: start held high, fresh operands every cycle
        phase = "R3";
        for (int k = 0; k < 41; k++) begin
            @(negedge clk);
            in_valid = 1'b1;
            a_in = (k % 2 == 0) ? '1 : rnd256();
            b_in = (k % 3 == 0) ? 256'd7 : rnd256();
        end
        @(negedge clk);
        in_valid = 1'b0;
        idle(12);
        // R4: starts offered inside a running operation
        phase = "R4";
        for (int off = 1; off <= 9; off++) begin
            @(negedge clk);
            in_valid = 1'b1; a_in = rnd256(); b_in = rnd256();
            @(negedge clk);
            in_valid = 1'b0;
            idle(off - 1);
            in_valid = 1'b1; a_in = rnd256(); b_in = rnd256();
            @(negedge clk);
            in_valid = 1'b0;
            idle(20);
        end
        // R6: random traffic with random gaps
        phase = "R6";
        for (int k = 0; k < 30; k++) begin
            give(rnd256(), ($urandom % 4 == 0) ? '0 : rnd256());
            idle($urandom % 10);
        end
        idle(20);
        // R7: reset in the middle of an operation
        phase = "R7";
        give(rnd256(), rnd256());
        idle(3);
        rst = 1'b1;
        idle(3);
        rst = 1'b0;
        idle(15);
        checks++;
        if (results < 40) begin
            bad++;
            $display("FAIL R3 too few results: got=%0d expected>=%0d", results, 40);
        end
        $display("test done: total=%0d bad=%0d", checks, bad);
        $finish;
    end

    initial begin
        #1000000;
        bad++;
        checks++;
        $display("FAIL watchdog: cycle=%0d expected=end of stimulus", cyc);
        $display("test done: total=%0d bad=%0d", checks, bad);
        $finish;
    end

endmodule